// File: doc/BRIEF.md
# Color Palette Lookup Pixel Pipeline

This block turns a stream of 8-bit pixel indices into 24-bit colors (red, green and blue, eight bits each) for three video DACs. On every rising pixel clock edge it captures a pixel index, a 4-bit overlay select, an active-low sync control and an active-low blank control. The index is ANDed with a read mask and then looked up in a 256-entry palette memory. A nonzero overlay select bypasses the palette and chooses one of 15 overlay color registers instead. Blanking and sync are then applied, and the channel codes and flags leave the block exactly four clocks after the capture edge.

Each output channel carries its own blank flag and sync flag. A setup flag reports the pedestal setting on visible pixels. A narrow-channel mode reduces every code to six significant bits. A byte-wide write port loads the palette, the overlay registers and the mask. A palette entry is committed only when its last byte arrives, so a half-written color is never shown. The pedestal and mode inputs are static configuration. The reset input is asserted asynchronously and released through a two-flop synchronizer.

Top module: `palette_pixel_pipe`

## Requirements
- R1: While reset is asserted all channel codes are 0, all three blank flags are 1, all sync flags are 0 and the setup flag is 0; the read mask resets to all ones, so indices are looked up unmasked until the mask is written.
- R2: A pixel whose inputs are sampled at rising edge n is shown on the outputs right after rising edge n+4, and the previous pixel is still shown between edges n+3 and n+4.
- R3: With overlay select 0 and blank_n high, the output color is palette entry (pix_idx AND mask), with red in bits 23:16, green in 15:8 and blue in 7:0 of the entry.
- R4: Palette writes (wr_target 0) arrive as three bytes in the order red, green, blue. The entry at the wr_addr of the third byte is updated only when that byte is written. The first two bytes leave the displayed color unchanged, and overlay or mask writes do not disturb the byte count.
- R5: An overlay select of 1 to 15 outputs overlay register 1 to 15, whatever the pixel index is.
- R6: An overlay write (wr_target 1) sets one byte at once. wr_addr[3:0] selects the register (1 to 15), and wr_addr[5:4] selects the channel: 0 red, 1 green, 2 blue.
- R7: A mask write (wr_target 2) loads wr_data into the read mask, and later palette lookups use the index ANDed with it.
- R8: With blank_n low, all codes are 0, all three blank flags are 1 and setup is 0, whatever the index and overlay inputs are.
- R9: With sync_n low, all three sync flags are 1. The codes and blank flags stay as they would be with sync_n high.
- R10: The setup flag equals pedestal_en for visible pixels and is 0 for blanked pixels.
- R11: With mode_8bit low, bits 7:6 of every channel code are 0 and bits 5:0 are the stored byte's low six bits. With mode_8bit high, the full byte is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_idx | input | 8 | Pixel index |
| ovl_sel | input | 4 | Overlay select, 0 = palette |
| sync_n | input | 1 | Active-low sync control |
| blank_n | input | 1 | Active-low blank control |
| pedestal_en | input | 1 | Pedestal setting reported on setup_o |
| mode_8bit | input | 1 | 1 = 8-bit codes, 0 = 6-bit codes |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_target | input | 2 | 0 palette, 1 overlay, 2 mask |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write byte |
| red_o | output | 8 | Red channel code |
| green_o | output | 8 | Green channel code |
| blue_o | output | 8 | Blue channel code |
| blank_flag_o | output | 3 | Per-channel blank flag (red, green, blue) |
| sync_cut_o | output | 3 | Per-channel sync flag (red, green, blue) |
| setup_o | output | 1 | Pedestal flag for visible pixels |

## Verification
Every pixel result is due exactly four rising edges after the edge that samples it. The bench drives pixel inputs on a falling edge and waits five rising edges, the first being the capture edge. It then samples the outputs on the following falling edge. The latency scenario also samples after the fourth edge to confirm that the old pixel is still shown. Writes take effect on the edge that samples them, and each write is finished well before any pixel that depends on it.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    TGT_PAL  = 2'd0,
    TGT_OVL  = 2'd1,
    TGT_MASK = 2'd2,
    TGT_NONE = 2'd3
  } wr_tgt_e;

  typedef struct packed {
    logic sync_n;
    logic blank_n;
  } pix_ctl_t;

  localparam pix_ctl_t CTL_RESET = '{sync_n: 1'b1, blank_n: 1'b0};
endpackage

// File: rtl/palette_cfg_regs.sv
module palette_cfg_regs import palette_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int OVL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_target,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [CH_W-1:0]      wr_data,
  input  logic [OVL_W-1:0]     ovl_rd_sel,
  output logic [3*CH_W-1:0]    ovl_color,
  output logic [IDX_W-1:0]     mask,
  output logic                 pal_we,
  output logic [IDX_W-1:0]     pal_waddr,
  output logic [3*CH_W-1:0]    pal_wdata
);
  localparam int COLOR_W = 3 * CH_W;
  localparam int OVL_N   = (1 << OVL_W) - 1;

  logic [1:0]                byte_cnt_q, byte_cnt_d;
  logic [CH_W-1:0]           stage_r_q, stage_g_q, stage_r_d, stage_g_d;
  logic [IDX_W-1:0]          mask_d;
  logic                      pal_hit, ovl_hit, mask_hit;
  logic [OVL_W-1:0]          ovl_idx;
  logic [1:0]                ovl_ch;
  logic [OVL_N*COLOR_W-1:0]  ovl_flat;

  assign pal_hit  = wr_en && (wr_target == TGT_PAL);
  assign ovl_hit  = wr_en && (wr_target == TGT_OVL);
  assign mask_hit = wr_en && (wr_target == TGT_MASK);
  assign ovl_idx  = wr_addr[OVL_W-1:0];
  assign ovl_ch   = wr_addr[OVL_W+1:OVL_W];

  always_comb begin
    byte_cnt_d = byte_cnt_q;
    stage_r_d  = stage_r_q;
    stage_g_d  = stage_g_q;
    mask_d     = mask;
    if (pal_hit) begin
      byte_cnt_d = (byte_cnt_q == 2'd2) ? 2'd0 : byte_cnt_q + 2'd1;
      if (byte_cnt_q == 2'd0) stage_r_d = wr_data;
      if (byte_cnt_q == 2'd1) stage_g_d = wr_data;
    end
    if (mask_hit) mask_d = wr_data[IDX_W-1:0];
  end

  assign pal_we    = pal_hit && (byte_cnt_q == 2'd2);
  assign pal_waddr = wr_addr;
  assign pal_wdata = {stage_r_q, stage_g_q, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt_q <= 2'd0;
      stage_r_q  <= '0;
      stage_g_q  <= '0;
      mask       <= '1;
    end else begin
      if (pal_hit) begin
        byte_cnt_q <= byte_cnt_d;
        stage_r_q  <= stage_r_d;
        stage_g_q  <= stage_g_d;
      end
      if (mask_hit) mask <= mask_d;
    end
  end

  for (genvar k = 1; k <= OVL_N; k++) begin : g_ovl
    logic [COLOR_W-1:0] reg_q, reg_d;
    logic               reg_en;
    assign reg_en = ovl_hit && (ovl_idx == OVL_W'(k)) && (ovl_ch != 2'd3);
    always_comb begin
      reg_d = reg_q;
      for (int c = 0; c < 3; c++)
        if (ovl_ch == 2'(c)) reg_d[(2-c)*CH_W +: CH_W] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= '0;
      else if (reg_en) reg_q <= reg_d;
    end
    assign ovl_flat[(k-1)*COLOR_W +: COLOR_W] = reg_q;
  end

  always_comb begin
    ovl_color = '0;
    for (int k = 1; k <= OVL_N; k++)
      if (ovl_rd_sel == OVL_W'(k)) ovl_color = ovl_flat[(k-1)*COLOR_W +: COLOR_W];
  end

  // R4: a commit always closes a three-byte sequence
  assert_commit_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |=> (byte_cnt_q == 2'd0));
  // R6: overlay and mask writes never commit a palette entry
  assert_no_pal_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_hit || mask_hit) |-> !pal_we);
endmodule

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)    mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage import palette_pkg::*; #(
  parameter int CH_W     = 8,
  parameter int NARROW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3*CH_W-1:0] color,
  input  pix_ctl_t          ctl,
  input  logic              pedestal_en,
  input  logic              mode_8bit,
  output logic [CH_W-1:0]   red_o,
  output logic [CH_W-1:0]   green_o,
  output logic [CH_W-1:0]   blue_o,
  output logic [2:0]        blank_flag_o,
  output logic [2:0]        sync_cut_o,
  output logic              setup_o
);
  localparam logic [CH_W-1:0] NARROW_MASK = CH_W'((1 << NARROW_W) - 1);

  logic [CH_W-1:0] ch_mask;
  logic [CH_W-1:0] red_d, green_d, blue_d;
  logic [2:0]      blank_d, sync_d;
  logic            setup_d;

  always_comb begin
    ch_mask = mode_8bit ? '1 : NARROW_MASK;
    red_d   = ctl.blank_n ? (color[3*CH_W-1:2*CH_W] & ch_mask) : '0;
    green_d = ctl.blank_n ? (color[2*CH_W-1:CH_W]   & ch_mask) : '0;
    blue_d  = ctl.blank_n ? (color[CH_W-1:0]        & ch_mask) : '0;
    blank_d = {3{~ctl.blank_n}};
    sync_d  = {3{~ctl.sync_n}};
    setup_d = pedestal_en & ctl.blank_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_o        <= '0;
      green_o      <= '0;
      blue_o       <= '0;
      blank_flag_o <= 3'b111;
      sync_cut_o   <= 3'b000;
      setup_o      <= 1'b0;
    end else begin
      red_o        <= red_d;
      green_o      <= green_d;
      blue_o       <= blue_d;
      blank_flag_o <= blank_d;
      sync_cut_o   <= sync_d;
      setup_o      <= setup_d;
    end
  end

  // R8: a blanked channel carries code zero
  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|blank_flag_o) |-> ({red_o, green_o, blue_o} == '0));
  // R10: no pedestal flag on blanked pixels
  assert_setup_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|blank_flag_o) |-> !setup_o);
  // R11: narrow mode keeps the upper code bits clear
  assert_narrow_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_8bit) |->
      (((red_o | green_o | blue_o) & ~NARROW_MASK) == '0));
endmodule

// File: rtl/palette_pixel_pipe.sv
module palette_pixel_pipe import palette_pkg::*; #(
  parameter int IDX_W    = 8,
  parameter int CH_W     = 8,
  parameter int NARROW_W = 6,
  parameter int OVL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [OVL_W-1:0] ovl_sel,
  input  logic             sync_n,
  input  logic             blank_n,
  input  logic             pedestal_en,
  input  logic             mode_8bit,
  input  logic             wr_en,
  input  logic [1:0]       wr_target,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [CH_W-1:0]  wr_data,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  green_o,
  output logic [CH_W-1:0]  blue_o,
  output logic [2:0]       blank_flag_o,
  output logic [2:0]       sync_cut_o,
  output logic             setup_o
);
  localparam int COLOR_W = 3 * CH_W;

  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [IDX_W-1:0]   s1_idx;
  logic [OVL_W-1:0]   s1_ovl;
  pix_ctl_t           s1_ctl;
  logic [IDX_W-1:0]   s2_addr, s2_addr_d;
  logic [OVL_W-1:0]   s2_ovl, s2_ovl_d;
  pix_ctl_t           s2_ctl;
  logic [COLOR_W-1:0] s3_ovl_color;
  logic               s3_use_ovl;
  pix_ctl_t           s3_ctl;
  logic [COLOR_W-1:0] s4_color, s4_color_d;
  pix_ctl_t           s4_ctl;

  logic [IDX_W-1:0]   mask;
  logic [COLOR_W-1:0] ovl_color, pal_rdata, pal_wdata;
  logic [IDX_W-1:0]   pal_waddr;
  logic               pal_we;

  palette_cfg_regs #(.IDX_W(IDX_W), .CH_W(CH_W), .OVL_W(OVL_W)) u_cfg (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en(wr_en), .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovl_rd_sel(s2_ovl), .ovl_color(ovl_color), .mask(mask),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata)
  );

  palette_ram #(.AW(IDX_W), .DW(COLOR_W)) u_ram (
    .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .rd_en(s2_ctl.blank_n), .raddr(s2_addr), .rdata(pal_rdata)
  );

  always_comb begin
    s2_addr_d  = s1_idx & mask;
    s2_ovl_d   = s1_ctl.blank_n ? s1_ovl : '0;
    s4_color_d = s3_use_ovl ? s3_ovl_color : pal_rdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_idx       <= '0;
      s1_ovl       <= '0;
      s1_ctl       <= CTL_RESET;
      s2_addr      <= '0;
      s2_ovl       <= '0;
      s2_ctl       <= CTL_RESET;
      s3_ovl_color <= '0;
      s3_use_ovl   <= 1'b0;
      s3_ctl       <= CTL_RESET;
      s4_color     <= '0;
      s4_ctl       <= CTL_RESET;
    end else begin
      s1_idx       <= pix_idx;
      s1_ovl       <= ovl_sel;
      s1_ctl       <= '{sync_n: sync_n, blank_n: blank_n};
      s2_addr      <= s2_addr_d;
      s2_ovl       <= s2_ovl_d;
      s2_ctl       <= s1_ctl;
      s3_ovl_color <= ovl_color;
      s3_use_ovl   <= |s2_ovl;
      s3_ctl       <= s2_ctl;
      s4_color     <= s4_color_d;
      s4_ctl       <= s3_ctl;
    end
  end

  pix_out_stage #(.CH_W(CH_W), .NARROW_W(NARROW_W)) u_out (
    .clk(clk), .rst_n(rst_q_n),
    .color(s4_color), .ctl(s4_ctl),
    .pedestal_en(pedestal_en), .mode_8bit(mode_8bit),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .blank_flag_o(blank_flag_o), .sync_cut_o(sync_cut_o), .setup_o(setup_o)
  );

  // R2: blank captured four edges earlier reaches all channel flags
  assert_blank_latency_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(!s1_ctl.blank_n, 4) |-> (blank_flag_o == 3'b111));
  // R9: sync captured four edges earlier reaches all channel flags
  assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(!s1_ctl.sync_n, 4) |-> (sync_cut_o == 3'b111));
endmodule

// File: tb/palette_pixel_pipe_tb.sv
module palette_pixel_pipe_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_idx;
  logic [3:0] ovl_sel;
  logic       sync_n, blank_n, pedestal_en, mode_8bit;
  logic       wr_en;
  logic [1:0] wr_target;
  logic [7:0] wr_addr, wr_data;
  logic [7:0] red_o, green_o, blue_o;
  logic [2:0] blank_flag_o, sync_cut_o;
  logic       setup_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [23:0] pal_m [256];
  logic [23:0] ovl_m [16];
  logic [7:0]  mask_m;

  always #4 clk = ~clk;

  palette_pixel_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .ovl_sel(ovl_sel),
    .sync_n(sync_n), .blank_n(blank_n), .pedestal_en(pedestal_en),
    .mode_8bit(mode_8bit), .wr_en(wr_en), .wr_target(wr_target),
    .wr_addr(wr_addr), .wr_data(wr_data), .red_o(red_o), .green_o(green_o),
    .blue_o(blue_o), .blank_flag_o(blank_flag_o), .sync_cut_o(sync_cut_o),
    .setup_o(setup_o)
  );

  task automatic chk(input string req, input logic [23:0] e_rgb,
                     input logic [2:0] e_blk, input logic [2:0] e_sync,
                     input logic e_setup);
    vectors++;
    if ({red_o, green_o, blue_o, blank_flag_o, sync_cut_o, setup_o} !==
        {e_rgb, e_blk, e_sync, e_setup}) begin
      miscompares++;
      $display("FAIL %s: got rgb=%h blank=%b sync=%b setup=%b, expected rgb=%h blank=%b sync=%b setup=%b",
               req, {red_o, green_o, blue_o}, blank_flag_o, sync_cut_o, setup_o,
               e_rgb, e_blk, e_sync, e_setup);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input logic [7:0] idx, input logic [3:0] ovl);
    logic [23:0] c;
    c = (ovl != 4'd0) ? ovl_m[ovl] : pal_m[idx & mask_m];
    if (!mode_8bit) c = c & 24'h3F3F3F;
    return c;
  endfunction

  task automatic wr(input logic [1:0] tgt, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_target = tgt; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] c);
    wr(2'd0, a, c[23:16]);
    wr(2'd0, a, c[15:8]);
    wr(2'd0, a, c[7:0]);
    pal_m[a] = c;
  endtask

  task automatic ovl_write(input logic [3:0] n, input logic [23:0] c);
    wr(2'd1, {2'd0, 2'd0, n}, c[23:16]);
    wr(2'd1, {2'd0, 2'd1, n}, c[15:8]);
    wr(2'd1, {2'd0, 2'd2, n}, c[7:0]);
    ovl_m[n] = c;
  endtask

  task automatic drive(input logic [7:0] idx, input logic [3:0] ovl,
                       input logic s, input logic b);
    @(negedge clk);
    pix_idx = idx; ovl_sel = ovl; sync_n = s; blank_n = b;
  endtask

  task automatic px(input logic [7:0] idx, input logic [3:0] ovl,
                    input logic s, input logic b);
    drive(idx, ovl, s, b);
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_target = 2'd0; wr_addr = '0; wr_data = '0;
    pix_idx = '0; ovl_sel = '0; sync_n = 1'b0; blank_n = 1'b1;
    pedestal_en = 1'b1; mode_8bit = 1'b1; mask_m = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", 24'h0, 3'b111, 3'b000, 1'b0);
    sync_n = 1'b1; blank_n = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_palette;
    pal_write(8'hC5, 24'h12_34_56);
    pal_write(8'h05, 24'hA1_B2_C3);
    pal_write(8'h10, 24'h01_02_03);
    pal_write(8'h20, 24'hF0_E0_D0);
    px(8'hC5, 4'd0, 1'b1, 1'b1);
    chk("R1 mask resets to ones", exp_rgb(8'hC5, 4'd0), 3'b000, 3'b000, 1'b1);
    px(8'h10, 4'd0, 1'b1, 1'b1);
    chk("R3 palette lookup 0x10", 24'h01_02_03, 3'b000, 3'b000, 1'b1);
    px(8'h20, 4'd0, 1'b1, 1'b1);
    chk("R3 palette lookup 0x20", 24'hF0_E0_D0, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_partial;
    wr(2'd0, 8'h10, 8'h77);
    wr(2'd0, 8'h10, 8'h88);
    wr(2'd1, {2'd0, 2'd0, 4'd9}, 8'h5A);
    ovl_m[9][23:16] = 8'h5A;
    px(8'h10, 4'd0, 1'b1, 1'b1);
    chk("R4 two bytes leave color unchanged", 24'h01_02_03, 3'b000, 3'b000, 1'b1);
    wr(2'd0, 8'h10, 8'h99);
    pal_m[8'h10] = 24'h77_88_99;
    px(8'h10, 4'd0, 1'b1, 1'b1);
    chk("R4 third byte commits entry", 24'h77_88_99, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_latency;
    px(8'hC5, 4'd0, 1'b1, 1'b1);
    drive(8'h20, 4'd0, 1'b1, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 old pixel held through edge n+3", 24'h12_34_56, 3'b000, 3'b000, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 new pixel after edge n+4", 24'hF0_E0_D0, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_overlay;
    ovl_write(4'd3, 24'h33_44_55);
    ovl_write(4'd15, 24'hEE_DD_CC);
    px(8'h10, 4'd3, 1'b1, 1'b1);
    chk("R5 overlay 3 index 0x10", 24'h33_44_55, 3'b000, 3'b000, 1'b1);
    px(8'h20, 4'd3, 1'b1, 1'b1);
    chk("R5 overlay 3 index 0x20 ignored", 24'h33_44_55, 3'b000, 3'b000, 1'b1);
    px(8'hC5, 4'd15, 1'b1, 1'b1);
    chk("R6 overlay 15 channel bytes", 24'hEE_DD_CC, 3'b000, 3'b000, 1'b1);
    px(8'hC5, 4'd9, 1'b1, 1'b1);
    chk("R6 overlay 9 single red byte", exp_rgb(8'hC5, 4'd9), 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_mask;
    wr(2'd2, 8'h00, 8'h0F);
    mask_m = 8'h0F;
    px(8'hC5, 4'd0, 1'b1, 1'b1);
    chk("R7 mask 0x0F maps 0xC5 to 0x05", 24'hA1_B2_C3, 3'b000, 3'b000, 1'b1);
    wr(2'd2, 8'h00, 8'hFF);
    mask_m = 8'hFF;
    px(8'hC5, 4'd0, 1'b1, 1'b1);
    chk("R7 mask restored", 24'h12_34_56, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_blank;
    px(8'hC5, 4'd0, 1'b1, 1'b0);
    chk("R8 blank palette pixel", 24'h0, 3'b111, 3'b000, 1'b0);
    px(8'h20, 4'd15, 1'b1, 1'b0);
    chk("R8 blank overlay pixel", 24'h0, 3'b111, 3'b000, 1'b0);
  endtask

  task automatic t_sync;
    px(8'h00, 4'd0, 1'b0, 1'b0);
    chk("R9 sync during blank", 24'h0, 3'b111, 3'b111, 1'b0);
    px(8'h20, 4'd0, 1'b0, 1'b1);
    chk("R9 sync leaves color", 24'hF0_E0_D0, 3'b000, 3'b111, 1'b1);
  endtask

  task automatic t_setup;
    @(negedge clk); pedestal_en = 1'b0;
    px(8'h20, 4'd0, 1'b1, 1'b1);
    chk("R10 pedestal off", 24'hF0_E0_D0, 3'b000, 3'b000, 1'b0);
    @(negedge clk); pedestal_en = 1'b1;
    px(8'h20, 4'd3, 1'b1, 1'b1);
    chk("R10 pedestal on", 24'h33_44_55, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_narrow;
    @(negedge clk); mode_8bit = 1'b0;
    px(8'h20, 4'd0, 1'b1, 1'b1);
    chk("R11 six-bit palette codes", 24'h30_20_10, 3'b000, 3'b000, 1'b1);
    px(8'h00, 4'd15, 1'b1, 1'b1);
    chk("R11 six-bit overlay codes", 24'h2E_1D_0C, 3'b000, 3'b000, 1'b1);
    @(negedge clk); mode_8bit = 1'b1;
    px(8'h00, 4'd15, 1'b1, 1'b1);
    chk("R11 eight-bit codes again", 24'hEE_DD_CC, 3'b000, 3'b000, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ovl_m[i] = 24'h0;
    t_reset;
    t_palette;
    t_partial;
    t_latency;
    t_overlay;
    t_mask;
    t_blank;
    t_sync;
    t_setup;
    t_narrow;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule